// File: doc/BRIEF.md
# Wrap-Around Refill Set-Associative Read Cache

This block sits between a processor read port and a memory port that returns one word per cycle. Every read is looked up in a four-way set-associative store. A hit returns the addressed word one cycle after the request is accepted. On a miss, one request goes to memory for the missed word. Memory then returns the whole four-word block, starting at that word and wrapping around to the start of the block. The processor gets the missed word in the same cycle it arrives. The block is still written into the cache in full before the next request is taken.

The parameter `CONCURRENT` sets when the memory request goes out. When it is 0, the request is raised only after the lookup has found a miss. When it is 1, the request leaves in the cycle the processor request is accepted. If the lookup then hits, the request is withdrawn with a cancel strobe. The victim is the least recently used way of the set, except that an empty way is always filled first.

Top module: `wrapfill_cache`

## Requirements
- R1: A byte address is split as tag = bits [31:12], set index = bits [11:4], word-in-block = bits [3:2]. Bits [1:0] are ignored. Two addresses that differ only in bits [1:0] return the same word, and the same tag under a different index is a separate block.
- R2: When `cpuReady` is high and `cpuReq` is high, the request is accepted. For a hit, `cpuValid` is high in the next cycle only, and in sequential mode no memory request is made.
- R3: At most one way of a set matches a valid tag. On a hit, `cpuData` is the stored word chosen by bits [3:2].
- R4: On a miss, exactly one memory request is made with `memAddr` equal to the requested address with bits [1:0] cleared. The returned words, block word k then k+1, k+2, k+3 (mod 4), are stored at those positions, so later hits to any word of the block return memory's value.
- R5: The missed word is driven on `cpuData` with `cpuValid` high in the same cycle `memValid` presents it (the first returned word). `cpuValid` stays low for the other three words.
- R6: `cpuReady` is low from the cycle after acceptance until the fourth refill word has been taken, and is high again in the following cycle.
- R7: In sequential mode `memReq` is high only in the cycle after acceptance, and only on a miss. In concurrent mode `memReq` is high in the acceptance cycle, and `memCancel` is high in the next cycle exactly when the lookup hits. `memReq` is never high in two consecutive cycles.
- R8: When all ways of a set are valid, a miss replaces the way least recently hit or refilled.
- R9: The replaced way is invalid from refill start and valid again only after its fourth word. An access to the evicted tag afterwards misses.
- R10: After reset all ways are invalid, `cpuReady` is high and `cpuValid` is low. Misses to a set fill empty ways, lowest-numbered way first, before any valid way is replaced.
- R11: The memory port is assumed to return the first word no earlier than two cycles after the cycle in which `memReq` is high, and the four words on consecutive `memValid` cycles. A cancel drops the pending stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuReq | input | 1 | Processor read request |
| cpuAddr | input | 32 | Processor byte address |
| cpuReady | output | 1 | Request can be accepted this cycle |
| cpuValid | output | 1 | Read data valid |
| cpuData | output | 32 | Read data word |
| memReq | output | 1 | Start a wrap-order block fetch |
| memCancel | output | 1 | Drop the fetch issued in the previous cycle |
| memAddr | output | 32 | Word-aligned address of the first word to fetch |
| memValid | input | 1 | Memory word valid |
| memData | input | 32 | Memory word |

## Verification
The assertions check the invariants on every cycle:
- a lookup never matches two ways;
- the age values of the addressed set always form a permutation;
- the way being refilled is never valid while its words are written;
- a reply or a memory request never lasts two cycles;
- the cycle after a forwarded word never shows ready.

Only the bench scenarios can show the rest, by comparing every cycle against a recency-list model of each set:
- the wrap-order storage of each word;
- forwarding in the arrival cycle;
- which way is evicted;
- the different request and cancel timing of the two modes.

// File: rtl/cache_pkg.sv
package cache_pkg;

  // Strobes from the sequencer to the storage datapath
  typedef struct packed {
    logic latchAddr;   // capture the accepted address
    logic startFill;   // choose victim, write tag, drop its valid bit
    logic writeWord;   // store the arriving memory word
    logic finishFill;  // mark victim valid, make it most recent
    logic touchHit;    // make the hit way most recent
  } cacheStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/cache_dp.sv
module cache_dp
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int SETS   = 256,
  parameter int WAYS   = 4,
  parameter int WORDS  = 4,
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int BLK_W  = WORDS * WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  cacheStrobe_t       strobe,
  input  logic [OFF_W-1:0]   fillCnt,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [WORD_W-1:0]  memData,
  output logic               hit,
  output logic [WORD_W-1:0]  hitData,
  output logic [ADDR_W-1:0]  reqAddr
);

  logic [ADDR_W-1:0] addrQ;
  logic [TAG_W-1:0]  tagQ;
  logic [IDX_W-1:0]  idxQ;
  logic [OFF_W-1:0]  offQ;

  assign tagQ    = addrQ[ADDR_W-1 -: TAG_W];
  assign idxQ    = addrQ[BYTE_W+OFF_W +: IDX_W];
  assign offQ    = addrQ[BYTE_W +: OFF_W];
  assign reqAddr = addrQ;

  logic [TAG_W-1:0] tagArr   [SETS][WAYS];
  logic [BLK_W-1:0] dataArr  [SETS][WAYS];
  logic [WAYS-1:0]  validArr [SETS];
  logic [WAY_W-1:0] ageArr   [SETS][WAYS];

  // Parallel tag compare, one comparator per way
  logic [WAYS-1:0] matchVec;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign matchVec[w] = validArr[idxQ][w] && (tagArr[idxQ][w] == tagQ);
  end
  assign hit = |matchVec;

  // Way multiplexer (AND-OR) followed by the word multiplexer
  logic [WAY_W-1:0] hitWay;
  logic [BLK_W-1:0] hitBlock;
  always_comb begin
    hitWay   = '0;
    hitBlock = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (matchVec[w]) begin
        hitWay   = WAY_W'(w);
        hitBlock = hitBlock | dataArr[idxQ][w];
      end
    end
  end
  assign hitData = hitBlock[offQ*WORD_W +: WORD_W];

  // Victim: lowest empty way, else the way holding the oldest age
  logic [WAY_W-1:0] victimWay;
  logic             emptyFound;
  always_comb begin
    victimWay  = '0;
    emptyFound = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!emptyFound && !validArr[idxQ][w]) begin
        victimWay  = WAY_W'(w);
        emptyFound = 1'b1;
      end
    end
    if (!emptyFound) begin
      for (int w = 0; w < WAYS; w++) begin
        if (ageArr[idxQ][w] == WAY_W'(WAYS - 1)) victimWay = WAY_W'(w);
      end
    end
  end

  logic [WAY_W-1:0] victimQ;
  logic [OFF_W-1:0] fillPos;
  assign fillPos = offQ + fillCnt;   // wraps inside the block

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      victimQ <= '0;
    end else begin
      if (strobe.latchAddr) addrQ <= cpuAddr;
      if (strobe.startFill) victimQ <= victimWay;
    end
  end

  // Tag and data storage carry no reset
  always_ff @(posedge clk) begin
    if (strobe.startFill) tagArr[idxQ][victimWay] <= tagQ;
    if (strobe.writeWord) dataArr[idxQ][victimQ][fillPos*WORD_W +: WORD_W] <= memData;
  end

  // Valid bits and recency ages
  logic             touchEn;
  logic [WAY_W-1:0] touchWay;
  assign touchEn  = strobe.touchHit | strobe.finishFill;
  assign touchWay = strobe.finishFill ? victimQ : hitWay;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        for (int w = 0; w < WAYS; w++) ageArr[s][w] <= WAY_W'(WAYS - 1 - w);
      end
    end else begin
      if (strobe.startFill)  validArr[idxQ][victimWay] <= 1'b0;
      if (strobe.finishFill) validArr[idxQ][victimQ]   <= 1'b1;
      if (touchEn) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touchWay)
            ageArr[idxQ][w] <= '0;
          else if (ageArr[idxQ][w] < ageArr[idxQ][touchWay])
            ageArr[idxQ][w] <= ageArr[idxQ][w] + 1'b1;
        end
      end
    end
  end

  logic [WAYS-1:0] ageMask;
  always_comb begin
    ageMask = '0;
    for (int w = 0; w < WAYS; w++) ageMask[ageArr[idxQ][w]] = 1'b1;
  end

  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(matchVec));  // R3
  AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (rst)
    ageMask == '1);  // R8
  AST_FILL_WAY_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    strobe.writeWord |-> !validArr[idxQ][victimQ]);  // R9

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter bit CONCURRENT = 1'b0,
  parameter int WORDS      = 4,
  localparam int OFF_W     = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpuReq,
  input  logic             hit,
  input  logic             memValid,
  output logic             cpuReady,
  output logic             cpuValid,
  output logic             fwdSel,
  output logic             memReq,
  output logic             memCancel,
  output logic             addrSel,
  output cacheStrobe_t     strobe,
  output logic [OFF_W-1:0] fillCnt
);

  localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(WORDS - 1);

  ctrlState_t       state, stateNext;
  logic [OFF_W-1:0] cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = fillCnt;
    strobe    = '0;
    cpuReady  = 1'b0;
    cpuValid  = 1'b0;
    fwdSel    = 1'b0;
    memReq    = 1'b0;
    memCancel = 1'b0;
    addrSel   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpuReady = 1'b1;
        addrSel  = 1'b1;
        if (cpuReq) begin
          strobe.latchAddr = 1'b1;
          memReq           = CONCURRENT;
          stateNext        = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          strobe.touchHit = 1'b1;
          cpuValid        = 1'b1;
          memCancel       = CONCURRENT;
          stateNext       = ST_IDLE;
        end else begin
          strobe.startFill = 1'b1;
          memReq           = !CONCURRENT;
          cntNext          = '0;
          stateNext        = ST_FILL;
        end
      end
      ST_FILL: begin
        if (memValid) begin
          strobe.writeWord = 1'b1;
          if (fillCnt == '0) begin
            cpuValid = 1'b1;
            fwdSel   = 1'b1;
          end
          cntNext = fillCnt + 1'b1;
          if (fillCnt == LAST_WORD) begin
            strobe.finishFill = 1'b1;
            stateNext         = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      fillCnt <= '0;
    end else begin
      state   <= stateNext;
      fillCnt <= cntNext;
    end
  end

  AST_SINGLE_REPLY: assert property (@(posedge clk) disable iff (rst)
    cpuValid |=> !cpuValid);  // R5
  AST_ONE_MEM_REQ: assert property (@(posedge clk) disable iff (rst)
    memReq |=> !memReq);  // R7
  AST_BUSY_AFTER_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (cpuValid && fwdSel) |=> !cpuReady);  // R6

endmodule

// File: rtl/wrapfill_cache.sv
module wrapfill_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int SETS       = 256,
  parameter int WAYS       = 4,
  parameter int WORDS      = 4,
  parameter bit CONCURRENT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuReady,
  output logic              cpuValid,
  output logic [WORD_W-1:0] cpuData,
  output logic              memReq,
  output logic              memCancel,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [WORD_W-1:0] memData
);

  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int OFF_W  = $clog2(WORDS);

  cacheStrobe_t      strobe;
  logic [OFF_W-1:0]  fillCnt;
  logic              hit, fwdSel, addrSel;
  logic [WORD_W-1:0] hitData;
  logic [ADDR_W-1:0] reqAddr;

  cache_ctrl #(.CONCURRENT(CONCURRENT), .WORDS(WORDS)) ctrl_i (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .hit(hit), .memValid(memValid),
    .cpuReady(cpuReady), .cpuValid(cpuValid), .fwdSel(fwdSel),
    .memReq(memReq), .memCancel(memCancel), .addrSel(addrSel),
    .strobe(strobe), .fillCnt(fillCnt)
  );

  cache_dp #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .SETS(SETS), .WAYS(WAYS),
             .WORDS(WORDS)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .fillCnt(fillCnt),
    .cpuAddr(cpuAddr), .memData(memData), .hit(hit), .hitData(hitData),
    .reqAddr(reqAddr)
  );

  // Concurrent mode fetches from the incoming address, sequential from the held one
  assign memAddr = addrSel ? {cpuAddr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}}
                           : {reqAddr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
  assign cpuData = fwdSel ? memData : hitData;

endmodule

// File: tb/wrapfill_cache_tb_top.sv
module tb_mem_model #(parameter int LAT = 2) (
  input  logic        clk,
  input  logic        rst,
  input  logic        memReq,
  input  logic        memCancel,
  input  logic [31:0] memAddr,
  output logic        memValid,
  output logic [31:0] memData
);
  logic        busy;
  int          dly;
  logic [31:0] base;
  logic [1:0]  idx;
  logic [1:0]  wordSel;

  function automatic logic [31:0] wordOf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; dly <= 0; base <= '0; idx <= '0;
    end else if (memCancel) begin
      busy <= 1'b0;
    end else if (memReq) begin
      busy <= 1'b1; dly <= LAT; base <= memAddr; idx <= '0;
    end else if (busy) begin
      if (dly > 0) dly <= dly - 1;
      else begin
        idx <= idx + 2'd1;
        if (idx == 2'd3) busy <= 1'b0;
      end
    end
  end

  assign wordSel  = base[3:2] + idx;
  assign memValid = busy && (dly == 0);
  assign memData  = wordOf({base[31:4], wordSel, 2'b00});
endmodule

module wrapfill_cache_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic        cpuReq [2];
  logic [31:0] cpuAddr [2];
  logic        cpuReady [2], cpuValid [2], memReq [2], memCancel [2], memValid [2];
  logic [31:0] cpuData [2], memAddr [2], memData [2];

  int errors = 0;
  int checks = 0;
  int setTags [int][$];   // per set, tags from most to least recent

  wrapfill_cache #(.CONCURRENT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .cpuReq(cpuReq[0]), .cpuAddr(cpuAddr[0]),
    .cpuReady(cpuReady[0]), .cpuValid(cpuValid[0]), .cpuData(cpuData[0]),
    .memReq(memReq[0]), .memCancel(memCancel[0]), .memAddr(memAddr[0]),
    .memValid(memValid[0]), .memData(memData[0]));
  tb_mem_model mem0_i (.clk(clk), .rst(rst), .memReq(memReq[0]),
    .memCancel(memCancel[0]), .memAddr(memAddr[0]), .memValid(memValid[0]),
    .memData(memData[0]));

  wrapfill_cache #(.CONCURRENT(1'b1)) dut_c_i (
    .clk(clk), .rst(rst), .cpuReq(cpuReq[1]), .cpuAddr(cpuAddr[1]),
    .cpuReady(cpuReady[1]), .cpuValid(cpuValid[1]), .cpuData(cpuData[1]),
    .memReq(memReq[1]), .memCancel(memCancel[1]), .memAddr(memAddr[1]),
    .memValid(memValid[1]), .memData(memData[1]));
  tb_mem_model mem1_i (.clk(clk), .rst(rst), .memReq(memReq[1]),
    .memCancel(memCancel[1]), .memAddr(memAddr[1]), .memValid(memValid[1]),
    .memData(memData[1]));

  function automatic logic [31:0] wordOf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input bit ok, input string req, input string ctx,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, ctx, act, exp);
    end
  endtask

  task automatic access(input int m, input logic [31:0] a, input string ctx);
    int key, tag, words, guard, hitPos;
    bit expHit;
    logic [31:0] expD, aligned;
    tag = int'(a[31:12]);
    key = m * 256 + int'(a[11:4]);
    aligned = {a[31:2], 2'b00};
    expD = wordOf(aligned);
    expHit = 1'b0;
    hitPos = -1;
    if (setTags.exists(key))
      foreach (setTags[key][i]) if (setTags[key][i] == tag) begin expHit = 1'b1; hitPos = i; end

    @(negedge clk);
    check(cpuReady[m] == 1'b1, "R6", {ctx, " ready at accept"}, 32'(cpuReady[m]), 1);
    cpuReq[m] = 1'b1;
    cpuAddr[m] = a;
    #1;
    if (m == 1) begin
      check(memReq[m] == 1'b1, "R7", {ctx, " concurrent req"}, 32'(memReq[m]), 1);
      check(memAddr[m] == aligned, "R7", {ctx, " concurrent addr"}, memAddr[m], aligned);
    end else
      check(memReq[m] == 1'b0, "R7", {ctx, " no early req"}, 32'(memReq[m]), 0);

    @(negedge clk);
    cpuReq[m] = 1'b0;
    if (expHit) begin
      check(cpuValid[m] == 1'b1, "R2", {ctx, " hit reply"}, 32'(cpuValid[m]), 1);
      check(cpuData[m] == expD, "R3", {ctx, " hit data"}, cpuData[m], expD);
      if (m == 1)
        check(memCancel[m] == 1'b1, "R7", {ctx, " cancel on hit"}, 32'(memCancel[m]), 1);
      else
        check(memReq[m] == 1'b0, "R2", {ctx, " no fetch on hit"}, 32'(memReq[m]), 0);
      @(negedge clk);
      check(cpuValid[m] == 1'b0, "R2", {ctx, " single reply"}, 32'(cpuValid[m]), 0);
      check(cpuReady[m] == 1'b1, "R6", {ctx, " ready after hit"}, 32'(cpuReady[m]), 1);
      setTags[key].delete(hitPos);
      setTags[key].push_front(tag);
    end else begin
      check(cpuValid[m] == 1'b0, "R2", {ctx, " no reply on miss lookup"}, 32'(cpuValid[m]), 0);
      if (m == 0) begin
        check(memReq[m] == 1'b1, "R4", {ctx, " miss req"}, 32'(memReq[m]), 1);
        check(memAddr[m] == aligned, "R4", {ctx, " miss addr"}, memAddr[m], aligned);
      end else
        check(memCancel[m] == 1'b0, "R7", {ctx, " no cancel on miss"}, 32'(memCancel[m]), 0);
      words = 0;
      guard = 0;
      while (words < 4 && guard < 20) begin
        @(negedge clk);
        guard++;
        check(cpuReady[m] == 1'b0, "R6", {ctx, " busy during refill"}, 32'(cpuReady[m]), 0);
        if (memValid[m]) begin
          if (words == 0) begin
            check(cpuValid[m] == 1'b1, "R5", {ctx, " forward valid"}, 32'(cpuValid[m]), 1);
            check(cpuData[m] == expD, "R5", {ctx, " forward data"}, cpuData[m], expD);
          end else
            check(cpuValid[m] == 1'b0, "R5", {ctx, " no extra reply"}, 32'(cpuValid[m]), 0);
          words++;
        end else
          check(cpuValid[m] == 1'b0, "R5", {ctx, " idle refill cycle"}, 32'(cpuValid[m]), 0);
      end
      check(words == 4, "R11", {ctx, " refill completed"}, 32'(words), 4);
      @(negedge clk);
      check(cpuReady[m] == 1'b1, "R6", {ctx, " ready after refill"}, 32'(cpuReady[m]), 1);
      if (setTags.exists(key) && setTags[key].size() == 4) void'(setTags[key].pop_back());
      setTags[key].push_front(tag);
    end
  endtask

  task automatic runMode(input int m);
    logic [31:0] blkA, blkB, blkC, blkD, blkE;
    blkA = 32'h0001_2358;  // tag 0x00012, index 0x35, word 2
    blkB = 32'h0004_5354;
    blkC = 32'h0007_835C;
    blkD = 32'h000A_B350;
    blkE = 32'h000F_F35C;
    access(m, blkA, "R10 cold miss R4");
    for (int w = 0; w < 4; w++)
      access(m, {blkA[31:4], 2'(w), 2'b00}, "R4 wrap stored word");
    access(m, blkA | 32'h3, "R1 byte offset ignored");
    access(m, blkB, "R10 empty way fill");
    access(m, blkC, "R10 empty way fill");
    access(m, blkD, "R10 empty way fill");
    access(m, blkB, "R8 all ways resident");
    access(m, blkC, "R8 all ways resident");
    access(m, blkD, "R8 all ways resident");
    access(m, blkA, "R8 refresh oldest");
    access(m, blkE, "R8 evict oldest");
    access(m, blkB, "R9 evicted tag misses");
    access(m, blkA, "R8 recent block kept");
    access(m, blkE, "R8 new block hits");
    access(m, 32'h0001_2C58, "R1 other index separate");
    access(m, 32'h0001_2C50, "R4 other index wrap");
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin cpuReq[m] = 1'b0; cpuAddr[m] = '0; end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check(cpuReady[m] == 1'b1, "R10", "reset ready", 32'(cpuReady[m]), 1);
      check(cpuValid[m] == 1'b0, "R10", "reset no reply", 32'(cpuValid[m]), 0);
    end
    runMode(0);
    runMode(1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule